// File: doc/BRIEF.md
# Expansion-Module Chip Select Decoder

This block turns a processor I/O cycle into the select strobes for two expansion-module connectors, called J7 and J6. It looks at the low byte of the I/O address, the active-low byte-high-enable and an I/O cycle strobe. From these it drives two active-low chip selects per connector. It also drives one active-low DMA acknowledge per connector and a terminate-DMA strobe that both connectors share.

Each connector has a width input. It tells the decoder whether the module on that connector is 16-bit or 8-bit.

- **16-bit module:** the connector's 16-port block is split into byte lanes. Chip select 0 follows the low lane (address bit 0 is 0). Chip select 1 follows the high lane (byte-high-enable is low).
- **8-bit module:** the two chip selects map to two consecutive 16-port blocks. Only even addresses are decoded.

A separate optional acknowledge port is steered to one connector by a configuration bit. Every output is combinational and is high whenever no I/O cycle is in progress.

Top module: `xmsel_decode`

## Requirements
- R1: While `io_cyc` is 0, every output (`j7_cs_n`, `j6_cs_n`, `j7_dack_n`, `j6_dack_n`, `term_n`) is high, whatever the other inputs are.
- R2: With a 16-bit module (width bit = 1), an access in the connector's low block (80h-8Fh for J7, A0h-AFh for J6) with address bit 0 = 0 drives chip select 0 (`cs_n[0]`) low. An even byte access (`bhe_n` = 1) leaves `cs_n[1]` high.
- R3: With a 16-bit module, an access in the low block with `bhe_n` = 0 drives `cs_n[1]` low. A word access at an even address therefore drives both selects low. A word or odd-byte access at an odd address (bit 0 = 1, `bhe_n` = 0) drives only `cs_n[1]` low.
- R4: With a 16-bit module, accesses in the connector's upper block (90h-9Fh for J7, B0h-BFh for J6) drive no chip select. An access with bit 0 = 1 and `bhe_n` = 1 also drives none.
- R5: With an 8-bit module (width bit = 0), even addresses in the low block drive `cs_n[0]` low. Even addresses in the upper block drive `cs_n[1]` low. The level of `bhe_n` does not change the result.
- R6: With an 8-bit module, odd addresses drive no chip select.
- R7: An access to port D4h drives `j7_dack_n` low. An access to port D6h drives `j6_dack_n` low. Both hold for either level of `bhe_n`.
- R8: An access to port D2h drives the acknowledge of J7 low when `opt_ack_j6` = 0, and that of J6 when it is 1.
- R9: An access to port F6h drives `term_n` low.
- R10: Every address not named in R2-R9 leaves all outputs high. At most one connector has a chip select low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_addr | input | 8 | Low byte of the I/O address |
| bhe_n | input | 1 | Byte-high-enable, active low |
| io_cyc | input | 1 | High while an I/O cycle is in progress |
| j7_wide | input | 1 | J7 module width: 1 = 16-bit, 0 = 8-bit |
| j6_wide | input | 1 | J6 module width: 1 = 16-bit, 0 = 8-bit |
| opt_ack_j6 | input | 1 | Routes the D2h acknowledge: 0 = J7, 1 = J6 |
| j7_cs_n | output | 2 | J7 chip selects, active low, [0] = CS0 |
| j6_cs_n | output | 2 | J6 chip selects, active low, [0] = CS0 |
| j7_dack_n | output | 1 | J7 DMA acknowledge, active low |
| j6_dack_n | output | 1 | J6 DMA acknowledge, active low |
| term_n | output | 1 | Terminate-DMA strobe to both connectors, active low |

## Verification
No register lies between the inputs and the outputs, so each result is due within the same cycle the inputs are applied. The bench changes the inputs just after a rising clock edge and compares the outputs at the following falling edge. By then the combinational paths have settled, and no edge race can reach the comparison. Directed tasks cover each width mode, lane case, acknowledge port and routing choice. A sweep then covers every address with every combination of strobe, byte enable, width bits and routing bit, against a model built from the requirements.

// File: rtl/xmsel_pkg.sv
// Package: shared widths and port constants for the expansion-module decoder.
// Assumes an 8-bit decoded I/O address; the ports are the fixed values the
// decoder responds to.
package xmsel_pkg;
    localparam int ADDR_W = 8;
    localparam int NUM_CONN = 2;
    localparam int CONN_J7 = 0;
    localparam int CONN_J6 = 1;
    typedef logic [ADDR_W-1:0] io_addr_t;
    typedef logic [NUM_CONN-1:0] conn_vec_t;
endpackage

// File: rtl/xmsel_conn_slice.sv
// Module: chip-select decode for one connector.
// Given the connector's base nibble, it decodes the low block (BASE) and the
// upper block (BASE+1). Lane split applies in 16-bit mode and block split in
// 8-bit mode. Assumes io_addr is stable during io_cyc.
module xmsel_conn_slice
    import xmsel_pkg::*;
#(
    parameter logic [3:0] BASE_NIB = 4'h8
) (
    input  io_addr_t   io_addr,
    input  logic       bhe_n,
    input  logic       io_cyc,
    input  logic       wide,
    output logic [1:0] cs_n
);
    localparam logic [3:0] UPPER_NIB = BASE_NIB + 4'd1;

    logic       in_low;
    logic       in_up;
    logic       even;
    logic [1:0] cs;

    // Block hit flags and low-lane flag.
    always_comb begin
        in_low = (io_addr[ADDR_W-1:4] == BASE_NIB);
        in_up  = (io_addr[ADDR_W-1:4] == UPPER_NIB);
        even   = ~io_addr[0];
    end

    // Select mapping for the configured module width.
    always_comb begin
        cs = 2'b00;
        if (io_cyc) begin
            if (wide) begin
                cs[0] = in_low & even;
                cs[1] = in_low & ~bhe_n;
            end else begin
                cs[0] = in_low & even;
                cs[1] = in_up & even;
            end
        end
        cs_n = ~cs;
    end

    // Local checks on the select outputs.
    always_comb begin
        // R6
        narrow_odd_quiet_chk: assert (wide || !io_addr[0] || (cs_n == 2'b11))
            else $error("8-bit module selected on odd address");
        // R4
        wide_upper_quiet_chk: assert (!wide || !in_up || (cs_n == 2'b11))
            else $error("16-bit module selected in upper block");
    end
endmodule

// File: rtl/xmsel_ack_decode.sv
// Module: DMA acknowledge and terminate-DMA port decode.
// Full 8-bit port compare; the optional acknowledge port is routed to one
// connector by opt_ack_j6. Byte-high-enable is not looked at.
module xmsel_ack_decode
    import xmsel_pkg::*;
#(
    parameter io_addr_t PORT_J7  = 8'hD4,
    parameter io_addr_t PORT_J6  = 8'hD6,
    parameter io_addr_t PORT_OPT = 8'hD2,
    parameter io_addr_t PORT_TRM = 8'hF6
) (
    input  io_addr_t  io_addr,
    input  logic      io_cyc,
    input  logic      opt_ack_j6,
    output conn_vec_t dack_n,
    output logic      term_n
);
    logic hit_j7, hit_j6, hit_opt, hit_trm;

    // Port hit flags, qualified by the cycle strobe.
    always_comb begin
        hit_j7  = io_cyc && (io_addr == PORT_J7);
        hit_j6  = io_cyc && (io_addr == PORT_J6);
        hit_opt = io_cyc && (io_addr == PORT_OPT);
        hit_trm = io_cyc && (io_addr == PORT_TRM);
    end

    // Acknowledge routing and strobe outputs.
    always_comb begin
        dack_n[CONN_J7] = ~(hit_j7 | (hit_opt & ~opt_ack_j6));
        dack_n[CONN_J6] = ~(hit_j6 | (hit_opt & opt_ack_j6));
        term_n          = ~hit_trm;
    end

    // Acknowledge exclusivity checks.
    always_comb begin
        // R7
        one_dack_chk: assert (dack_n != 2'b00)
            else $error("both acknowledges low");
        // R9
        term_alone_chk: assert (term_n || (dack_n == 2'b11))
            else $error("terminate strobe together with acknowledge");
    end
endmodule

// File: rtl/xmsel_decode.sv
// Module: top of the expansion-module chip select decoder.
// Instantiates one select slice per connector and the acknowledge decoder.
// Purely combinational; all outputs active low and idle high outside io_cyc.
module xmsel_decode
    import xmsel_pkg::*;
#(
    parameter logic [3:0] J7_NIB = 4'h8,
    parameter logic [3:0] J6_NIB = 4'hA
) (
    input  logic [7:0] io_addr,
    input  logic       bhe_n,
    input  logic       io_cyc,
    input  logic       j7_wide,
    input  logic       j6_wide,
    input  logic       opt_ack_j6,
    output logic [1:0] j7_cs_n,
    output logic [1:0] j6_cs_n,
    output logic       j7_dack_n,
    output logic       j6_dack_n,
    output logic       term_n
);
    conn_vec_t  wide_v;
    conn_vec_t  dack_v;
    logic [1:0] cs_v [NUM_CONN];

    // Pack per-connector width bits.
    always_comb begin
        wide_v[CONN_J7] = j7_wide;
        wide_v[CONN_J6] = j6_wide;
    end

    for (genvar g = 0; g < NUM_CONN; g++) begin : g_conn
        xmsel_conn_slice #(
            .BASE_NIB((g == CONN_J7) ? J7_NIB : J6_NIB)
        ) slice_i (
            .io_addr(io_addr),
            .bhe_n  (bhe_n),
            .io_cyc (io_cyc),
            .wide   (wide_v[g]),
            .cs_n   (cs_v[g])
        );
    end

    xmsel_ack_decode ack_i (
        .io_addr   (io_addr),
        .io_cyc    (io_cyc),
        .opt_ack_j6(opt_ack_j6),
        .dack_n    (dack_v),
        .term_n    (term_n)
    );

    // Drive the connector-named outputs.
    always_comb begin
        j7_cs_n   = cs_v[CONN_J7];
        j6_cs_n   = cs_v[CONN_J6];
        j7_dack_n = dack_v[CONN_J7];
        j6_dack_n = dack_v[CONN_J6];
    end

    // Top-level output checks.
    always_comb begin
        // R1
        idle_high_chk: assert (io_cyc ||
            ((j7_cs_n == 2'b11) && (j6_cs_n == 2'b11) && j7_dack_n && j6_dack_n && term_n))
            else $error("output active outside I/O cycle");
        // R10
        one_conn_chk: assert ((j7_cs_n == 2'b11) || (j6_cs_n == 2'b11))
            else $error("both connectors selected");
        // R10
        cs_vs_ack_chk: assert (((j7_cs_n & j6_cs_n) == 2'b11) || (j7_dack_n && j6_dack_n && term_n))
            else $error("chip select together with acknowledge port");
    end
endmodule

// File: tb/xmsel_decode_tb.sv
module xmsel_decode_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_LIMIT = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       bhe_n = 1'b1;
    logic       io_cyc = 1'b0;
    logic       j7_wide = 1'b1;
    logic       j6_wide = 1'b1;
    logic       opt_ack_j6 = 1'b0;
    logic [1:0] j7_cs_n, j6_cs_n;
    logic       j7_dack_n, j6_dack_n, term_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmsel_decode dut_i (
        .io_addr(io_addr), .bhe_n(bhe_n), .io_cyc(io_cyc),
        .j7_wide(j7_wide), .j6_wide(j6_wide), .opt_ack_j6(opt_ack_j6),
        .j7_cs_n(j7_cs_n), .j6_cs_n(j6_cs_n),
        .j7_dack_n(j7_dack_n), .j6_dack_n(j6_dack_n), .term_n(term_n)
    );

    // Packed output view: {j7_cs_n, j6_cs_n, j7_dack_n, j6_dack_n, term_n}
    function automatic logic [6:0] got();
        return {j7_cs_n, j6_cs_n, j7_dack_n, j6_dack_n, term_n};
    endfunction

    // Model from the requirements, active-high selects then inverted.
    function automatic logic [1:0] conn_sel(logic [7:0] a, logic bn, logic w, logic [3:0] nib);
        logic [1:0] s = 2'b00;
        if (a[7:4] == nib && w) begin
            s[0] = (a[0] == 1'b0);
            s[1] = (bn == 1'b0);
        end else if (!w && a[0] == 1'b0) begin
            if (a[7:4] == nib)         s[0] = 1'b1;
            if (a[7:4] == nib + 4'd1)  s[1] = 1'b1;
        end
        return ~s;
    endfunction

    function automatic logic [6:0] model(logic [7:0] a, logic bn, logic c,
                                         logic w7, logic w6, logic opt);
        logic [6:0] r;
        if (!c) return 7'h7F;
        r[6:5] = conn_sel(a, bn, w7, 4'h8);
        r[4:3] = conn_sel(a, bn, w6, 4'hA);
        r[2]   = ~((a == 8'hD4) || (a == 8'hD2 && !opt));
        r[1]   = ~((a == 8'hD6) || (a == 8'hD2 && opt));
        r[0]   = ~(a == 8'hF6);
        return r;
    endfunction

    task automatic drive(logic [7:0] a, logic bn, logic c, logic w7, logic w6, logic opt);
        @(posedge clk);
        #1;
        io_addr = a; bhe_n = bn; io_cyc = c;
        j7_wide = w7; j6_wide = w6; opt_ack_j6 = opt;
        @(negedge clk);
    endtask

    task automatic check(string req, logic [6:0] exp);
        checks++;
        if (got() !== exp) begin
            errors++;
            $display("FAIL %s addr=%h bhe_n=%b cyc=%b: got %b expected %b",
                     req, io_addr, bhe_n, io_cyc, got(), exp);
        end
    endtask

    // R1: idle outputs during reset and with strobe low
    task automatic t_idle();
        drive(8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); check("R1", 7'b11_11_111);
        drive(8'hD4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); check("R1", 7'b11_11_111);
        drive(8'hF6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1); check("R1", 7'b11_11_111);
    endtask

    // R2, R3, R4: 16-bit lane mapping
    task automatic t_wide();
        drive(8'h84, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); check("R2", 7'b10_11_111);
        drive(8'hAE, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); check("R2", 7'b11_10_111);
        drive(8'h8F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); check("R3", 7'b01_11_111);
        drive(8'h80, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); check("R3", 7'b00_11_111);
        drive(8'hA3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); check("R3", 7'b11_01_111);
        drive(8'h90, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); check("R4", 7'b11_11_111);
        drive(8'hB2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); check("R4", 7'b11_11_111);
        drive(8'h85, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); check("R4", 7'b11_11_111);
    endtask

    // R5, R6: 8-bit block mapping
    task automatic t_narrow();
        drive(8'h8E, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); check("R5", 7'b10_11_111);
        drive(8'h9E, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); check("R5", 7'b01_11_111);
        drive(8'hA0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); check("R5", 7'b11_10_111);
        drive(8'hB6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); check("R5", 7'b11_01_111);
        drive(8'h81, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); check("R6", 7'b11_11_111);
        drive(8'hB9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); check("R6", 7'b11_11_111);
    endtask

    // R7, R8, R9: acknowledge and terminate ports
    task automatic t_ack();
        drive(8'hD4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); check("R7", 7'b11_11_011);
        drive(8'hD4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); check("R7", 7'b11_11_011);
        drive(8'hD6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); check("R7", 7'b11_11_101);
        drive(8'hD2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); check("R8", 7'b11_11_011);
        drive(8'hD2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); check("R8", 7'b11_11_101);
        drive(8'hF6, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); check("R9", 7'b11_11_110);
        drive(8'hD5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); check("R10", 7'b11_11_111);
        drive(8'hC0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); check("R10", 7'b11_11_111);
    endtask

    // R10 and all others: exhaustive sweep against the model
    task automatic t_sweep();
        for (int k = 0; k < 8192; k++) begin
            logic [12:0] v = k[12:0];
            drive(v[7:0], v[8], v[9], v[10], v[11], v[12]);
            check("R10 sweep", model(v[7:0], v[8], v[9], v[10], v[11], v[12]));
        end
    endtask

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > WDOG_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected <= %0d", cycles, WDOG_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state: strobe low, all outputs idle (R1).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 7'b11_11_111);
        rst_n = 1'b1;
        t_idle();
        t_wide();
        t_narrow();
        t_ack();
        t_sweep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule